// File: doc/BRIEF.md
# Double-Precision Reciprocal Square Root Estimator

This unit takes one IEEE-754 binary64 operand per cycle and, a fixed three cycles later, returns an estimate of its reciprocal square root. The relative error is below 2^-14. Finite positive operands go through a split datapath. The exponent is unbiased, forced even by folding a factor of two into the mantissa when it is odd, then halved, negated and rebiased. The mantissa, scaled to [1,4), indexes a small seed table that is built when the design is elaborated. That seed is refined by one Newton-Raphson step in fixed point.

Operands that are not finite positive numbers bypass the arithmetic. Signed zeros, infinities, negative values and NaNs each produce a fixed result. A flush control decides whether subnormal operands count as signed zeros or are normalised and estimated like any other number. The result never depends on a rounding mode, and the unit signals no exceptions.

Top module: `rsqrt_estimator`

## Requirements
- R1: For every positive normal operand, the result is a positive normal number whose relative error against 1/sqrt(x) is below 2^-14, for both even and odd unbiased exponents.
- R2: An operand of +0 (0x0000000000000000) returns +infinity (0x7FF0000000000000), and -0 (0x8000000000000000) returns -infinity (0xFFF0000000000000).
- R3: An operand of +infinity (0x7FF0000000000000) returns +0 (0x0000000000000000).
- R4: Any negative operand that is not a zero and not a NaN, -infinity included, returns the default quiet NaN 0xFFF8000000000000. This includes negative subnormals when flushing is off.
- R5: A NaN operand (exponent field all ones, fraction nonzero, sign kept) is returned with fraction bit 51 forced to 1. A quiet NaN therefore comes back unchanged.
- R6: With `flush_sub` high, a subnormal operand (exponent field zero, fraction nonzero) returns infinity with the operand's sign.
- R7: With `flush_sub` low, a positive subnormal operand returns a normal, finite result within the R1 error bound. `flush_sub` has no effect on normal operands.
- R8: An operand equal to 2^(-2n), normal or subnormal, returns exactly 2^n: exponent field 1023+n, fraction zero.
- R9: `out_valid` is high exactly three clock edges after the edge that sampled `in_valid` high. A new operand is accepted on every cycle, and results emerge in order.
- R10: While `rst_n` is low at a clock edge, all pipeline stages are cleared and `out_valid` is low after that edge. A reset in mid-stream discards every operand in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | binary64 operand |
| flush_sub | input | 1 | 1: subnormal operands count as signed zeros |
| out_valid | output | 1 | Result strobe, three cycles after the operand |
| out_data | output | 64 | binary64 result |

## Verification
The estimate is tried against the real-valued reciprocal square root on operands placed at the lower edge, the middle and the upper edge of every seed interval. Each placement is run with both exponent parities, so a wrong table entry, a wrong parity scale or a wrong halving of the exponent each show up as a separate error. Exact powers of four are swept over the whole normal exponent range and into the subnormals, which separates the exact-result path from the merely accurate one. Subnormals are run with flushing on and off, and the bypass results are compared bit for bit. A back-to-back stream with changing exponents, followed by a reset in mid-stream, tells correct ordering and throughput apart from stale or lost pipeline data.

// File: rtl/rsqrt_pkg.sv
// Shared constants, stage payload types and the elaboration-time seed
// computation for the reciprocal square root estimator.
// Assumes binary64 operands and a seed table of at most a few hundred entries.
package rsqrt_pkg;

    localparam int DW   = 64;   // operand width
    localparam int EW   = 11;   // exponent field width
    localparam int FW   = 52;   // fraction field width
    localparam int XW   = 32;   // scaled mantissa width, two integer bits
    localparam int XF   = 30;   // scaled mantissa fraction bits

    localparam logic [DW-1:0] NAN_DEFAULT = 64'hFFF8_0000_0000_0000;
    localparam logic [DW-1:0] INF_POS     = 64'h7FF0_0000_0000_0000;
    localparam logic [DW-1:0] INF_NEG     = 64'hFFF0_0000_0000_0000;

    // Fields that ride alongside the arithmetic from unpack to pack.
    typedef struct packed {
        logic          special;   // result fully decided by classification
        logic [DW-1:0] spec_val;  // that result
        logic          exact;     // power of four: mantissa result is 1.0
        logic [EW-1:0] exp_base;  // biased result exponent before normalisation
    } tag_t;

    // Stage one payload.
    typedef struct packed {
        tag_t          tag;
        logic          odd;       // unbiased exponent was odd
        logic [FW-1:0] frac;      // fraction with the leading one implied
    } unpk_t;

    // Integer square root, floor, by bit-wise trial.
    function automatic logic [63:0] isqrt64(input logic [63:0] v);
        logic [63:0] res;
        logic [63:0] cand;
        res = '0;
        for (int k = 31; k >= 0; k--) begin
            cand = res | (64'd1 << k);
            if (cand * cand <= v) res = cand;
        end
        return res;
    endfunction

    // Seed for table slot idx: 2^sf / sqrt(interval midpoint), where the
    // slot's top bit picks a mantissa scale of 2 and the low tb bits pick
    // the interval inside [1,2).
    function automatic logic [63:0] seed_value(input int idx, input int tb, input int sf);
        logic [63:0] q;
        logic [63:0] p;
        logic [63:0] num;
        q   = (64'd1 << (tb + 1)) + 64'(2 * (idx % (1 << tb)) + 1);
        p   = (((idx >> tb) & 1) != 0) ? 64'd2 : 64'd1;
        num = 64'd1 << (2 * sf + tb + 1);
        return isqrt64(num / (q * p));
    endfunction

endpackage

// File: rtl/rsqrt_unpack.sv
// Stage one: classifies the operand, decides every bypass result,
// normalises subnormals, and derives the parity and halved exponent.
// Assumes one operand per cycle; output is registered.
module rsqrt_unpack
    import rsqrt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          flush_sub,
    output logic          a_valid,
    output unpk_t         a_q
);

    logic          sgn;
    logic [EW-1:0] ef;
    logic [FW-1:0] fr;
    logic          is_nan, is_inf, is_sub, is_zero;
    logic [5:0]    top;
    logic [FW:0]   shifted;
    logic signed [12:0] e_unb, e_even, half, base;
    unpk_t         nxt;

    // Field split and operand classification.
    always_comb begin
        sgn     = in_data[63];
        ef      = in_data[62:52];
        fr      = in_data[51:0];
        is_nan  = (ef == '1) && (fr != '0);
        is_inf  = (ef == '1) && (fr == '0);
        is_sub  = (ef == '0) && (fr != '0) && !flush_sub;
        is_zero = (ef == '0) && ((fr == '0) || flush_sub);
    end

    // Leading-one search and shift for subnormal operands.
    always_comb begin
        top = '0;
        for (int k = 0; k < FW; k++) begin
            if (fr[k]) top = 6'(k);
        end
        shifted = {1'b0, fr} << (6'(FW) - top);
    end

    // Exponent: unbias, force even, halve, negate and rebias.
    always_comb begin
        if (is_sub) e_unb = $signed({7'b0, top}) - 13'sd1074;
        else        e_unb = $signed({2'b0, ef}) - 13'sd1023;
        e_even = e_unb - $signed({12'b0, e_unb[0]});
        half   = e_even >>> 1;
        base   = 13'sd1023 - half;
    end

    // Payload assembly, bypass results in priority order.
    always_comb begin
        nxt              = '0;
        nxt.odd          = e_unb[0];
        nxt.frac         = is_sub ? shifted[FW-1:0] : fr;
        nxt.tag.exp_base = base[EW-1:0];
        nxt.tag.exact    = !e_unb[0] && (nxt.frac == '0);
        nxt.tag.special  = 1'b1;
        if (is_nan)       nxt.tag.spec_val = in_data | (64'd1 << 51);
        else if (is_zero) nxt.tag.spec_val = sgn ? INF_NEG : INF_POS;
        else if (sgn)     nxt.tag.spec_val = NAN_DEFAULT;
        else if (is_inf)  nxt.tag.spec_val = '0;
        else              nxt.tag.special  = 1'b0;
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_q     <= '0;
        end else begin
            a_valid <= in_valid;
            a_q     <= nxt;
        end
    end

    // R6: a flushed subnormal leaves this stage as infinity of its own sign.
    a_r6_flush_to_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flush_sub && in_data[62:52] == '0 && in_data[51:0] != '0)
        |=> (a_q.tag.special && a_q.tag.spec_val[62:0] == INF_POS[62:0]
             && a_q.tag.spec_val[63] == $past(in_data[63])));

endmodule

// File: rtl/rsqrt_seed_rom.sv
// Seed table for the reciprocal square root, one entry per
// (exponent parity, top TB fraction bits); contents computed at elaboration.
// Assumes TB small enough that 2^(TB+1) entries stay a few hundred.
module rsqrt_seed_rom
    import rsqrt_pkg::*;
#(
    parameter int TB = 6,
    parameter int SF = 16
) (
    input  logic [TB:0] idx,
    output logic [SF:0] seed
);

    localparam int NENT = 1 << (TB + 1);

    logic [SF:0] tbl [NENT];

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        localparam logic [63:0] V = seed_value(g, TB, SF);
        assign tbl[g] = V[SF:0];
    end

    assign seed = tbl[idx];

endmodule

// File: rtl/rsqrt_refine.sv
// Stage two: seed lookup and the first half of the Newton-Raphson step,
// u = 3 - x*y0*y0, in fixed point with XF fraction bits.
// Assumes the scaled mantissa lies in [1,4) and the seed in (0.5,1].
module rsqrt_refine
    import rsqrt_pkg::*;
#(
    parameter int TB = 6,
    parameter int SF = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    input  unpk_t         a_q,
    output logic          b_valid,
    output tag_t          b_tag,
    output logic [SF:0]   b_y0,
    output logic [XW-1:0] b_u
);

    localparam int SQW = 2 * SF + 2;
    localparam int PRW = XW + SQW;

    logic [TB:0]     idx;
    logic [SF:0]     y0;
    logic [FW:0]     m53;
    logic [XW-1:0]   xm;
    logic [SQW-1:0]  ysq;
    logic [PRW-1:0]  prod;
    logic [XW-1:0]   t;
    logic [XW-1:0]   u;

    assign idx = {a_q.odd, a_q.frac[FW-1 -: TB]};

    rsqrt_seed_rom #(.TB(TB), .SF(SF)) u_rom (
        .idx  (idx),
        .seed (y0)
    );

    // Scaled mantissa and the error term of the seed.
    always_comb begin
        m53  = {1'b1, a_q.frac};
        xm   = a_q.odd ? m53[FW -: XW] : {1'b0, m53[FW -: XW-1]};
        ysq  = {{(SF+1){1'b0}}, y0} * {{(SF+1){1'b0}}, y0};
        prod = {{SQW{1'b0}}, xm} * {{XW{1'b0}}, ysq};
        t    = prod[2*SF+XW-1 : 2*SF];
        u    = (XW'(3) << XF) - t;
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_tag   <= '0;
            b_y0    <= '0;
            b_u     <= '0;
        end else begin
            b_valid <= a_valid;
            b_tag   <= a_q.tag;
            b_y0    <= y0;
            b_u     <= u;
        end
    end

endmodule

// File: rtl/rsqrt_pack.sv
// Stage three: finishes y1 = y0*u/2, normalises it and packs the
// binary64 result, or forwards a bypass or exact result.
// Assumes y1 lies in (0.25,1]; at most two normalising shifts.
module rsqrt_pack
    import rsqrt_pkg::*;
#(
    parameter int SF = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          b_valid,
    input  tag_t          b_tag,
    input  logic [SF:0]   b_y0,
    input  logic [XW-1:0] b_u,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    localparam int PW  = SF + 1 + XW;
    localparam int ONE = SF + XF + 1;   // bit weight of 1.0 after the halving

    logic [PW-1:0]    y1;
    logic [1:0]       sh;
    logic [PW+FW-1:0] wide;
    logic [FW-1:0]    frac;
    logic [EW-1:0]    exp_n;
    logic [DW-1:0]    res;
    logic             out_special;

    // Final product and normalisation.
    always_comb begin
        y1 = {{XW{1'b0}}, b_y0} * {{(SF+1){1'b0}}, b_u};
        if (y1[ONE])        sh = 2'd0;
        else if (y1[ONE-1]) sh = 2'd1;
        else                sh = 2'd2;
        wide  = {y1, {FW{1'b0}}} << sh;
        frac  = wide[ONE+FW-1 -: FW];
        exp_n = b_tag.exp_base - EW'(sh);
    end

    // Result selection.
    always_comb begin
        if (b_tag.special)    res = b_tag.spec_val;
        else if (b_tag.exact) res = {1'b0, b_tag.exp_base, {FW{1'b0}}};
        else                  res = {1'b0, exp_n, frac};
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_special <= 1'b0;
        end else begin
            out_valid   <= b_valid;
            out_data    <= res;
            out_special <= b_tag.special;
        end
    end

    // R1/R7: a computed result is positive, normal and finite.
    a_r1_normal_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_special)
        |-> (!out_data[63] && out_data[62:52] != '0 && out_data[62:52] != '1));

    // R8: a power of four leaves with zero fraction and the halved exponent.
    a_r8_exact_power: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_tag.special && b_tag.exact)
        |=> (out_data[51:0] == '0 && out_data[62:52] == $past(b_tag.exp_base)));

endmodule

// File: rtl/rsqrt_estimator.sv
// Top of the reciprocal square root estimator: three registered stages
// (unpack, refine, pack), one operand per cycle, latency three.
// Assumes a synchronous active-low reset that clears every stage.
module rsqrt_estimator
    import rsqrt_pkg::*;
#(
    parameter int TB = 6,
    parameter int SF = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [63:0]   in_data,
    input  logic          flush_sub,
    output logic          out_valid,
    output logic [63:0]   out_data
);

    logic          a_valid;
    unpk_t         a_q;
    logic          b_valid;
    tag_t          b_tag;
    logic [SF:0]   b_y0;
    logic [XW-1:0] b_u;

    rsqrt_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .flush_sub (flush_sub),
        .a_valid   (a_valid),
        .a_q       (a_q)
    );

    rsqrt_refine #(.TB(TB), .SF(SF)) u_refine (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_valid (a_valid),
        .a_q     (a_q),
        .b_valid (b_valid),
        .b_tag   (b_tag),
        .b_y0    (b_y0),
        .b_u     (b_u)
    );

    rsqrt_pack #(.SF(SF)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .b_valid   (b_valid),
        .b_tag     (b_tag),
        .b_y0      (b_y0),
        .b_u       (b_u),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Checker support: cycles since reset, saturating at the latency.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // Checker support: operand classes seen at the input.
    logic in_pzero, in_nzero, in_pinf, in_nan, in_negnum;
    always_comb begin
        in_pzero  = (in_data == 64'h0);
        in_nzero  = (in_data == 64'h8000_0000_0000_0000);
        in_pinf   = (in_data == INF_POS);
        in_nan    = (in_data[62:52] == '1) && (in_data[51:0] != '0);
        in_negnum = in_data[63] && (in_data[62:52] != '0) && !in_nan;
    end

    // R9: results appear exactly three edges after their operand.
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2: signed zeros map to infinities of the same sign.
    a_r2_zero_to_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(in_valid, 3) && ($past(in_pzero, 3) || $past(in_nzero, 3)))
        |-> (out_data == ($past(in_data[63], 3) ? INF_NEG : INF_POS)));

    // R3: +infinity maps to +0.
    a_r3_inf_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(in_valid, 3) && $past(in_pinf, 3))
        |-> (out_data == 64'h0));

    // R4: negative numbers give the default quiet NaN.
    a_r4_negative_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(in_valid, 3) && $past(in_negnum, 3))
        |-> (out_data == NAN_DEFAULT));

    // R5: NaNs come back quieted, payload and sign kept.
    a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(in_valid, 3) && $past(in_nan, 3))
        |-> (out_data == ($past(in_data, 3) | (64'd1 << 51))));

endmodule

// File: tb/rsqrt_estimator_test.sv
// Directed bench for the reciprocal square root estimator.
module rsqrt_estimator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        flush_sub = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    localparam real ERR_LIM = 6.103515625e-5;   // 2^-14

    rsqrt_estimator uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .flush_sub (flush_sub),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] mk(input bit s, input int e, input logic [51:0] f);
        return {s, 11'(e), f};
    endfunction

    task automatic check_bits(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_close(input string req, input logic [63:0] x, input logic [63:0] got);
        real xr, rf, gr, err;
        total++;
        xr  = $bitstoreal(x);
        rf  = 1.0 / $sqrt(xr);
        gr  = $bitstoreal(got);
        err = (gr - rf) / rf;
        if (err < 0.0) err = -err;
        if (got[63] || got[62:52] == 11'h0 || got[62:52] == 11'h7FF || !(err < ERR_LIM)) begin
            bad++;
            $display("FAIL %s: x=%h got %h (%e) expected %e rel err %e", req, x, got, gr, rf, err);
        end
    endtask

    // One operand, wait out the latency, return the result and its strobe.
    task automatic apply(input logic [63:0] x, input bit daz, output logic [63:0] y, output bit v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = x;
        flush_sub = daz;
        @(negedge clk);
        in_valid  = 1'b0;
        repeat (2) @(negedge clk);
        y = out_data;
        v = out_valid;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R10: out_valid during reset got %b expected 0", out_valid);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R10: out_valid after idle reset got %b expected 0", out_valid);
        end
    endtask

    task automatic t_specials();
        logic [63:0] y;
        bit v;
        apply(64'h0, 1'b0, y, v);                    check_bits("R2 +0", y, 64'h7FF0_0000_0000_0000);
        apply(64'h8000_0000_0000_0000, 1'b0, y, v);  check_bits("R2 -0", y, 64'hFFF0_0000_0000_0000);
        apply(64'h7FF0_0000_0000_0000, 1'b0, y, v);  check_bits("R3 +inf", y, 64'h0);
        apply(64'hFFF0_0000_0000_0000, 1'b0, y, v);  check_bits("R4 -inf", y, 64'hFFF8_0000_0000_0000);
        apply(64'hBFF0_0000_0000_0000, 1'b0, y, v);  check_bits("R4 -1.0", y, 64'hFFF8_0000_0000_0000);
        apply(64'hFFEF_FFFF_FFFF_FFFF, 1'b0, y, v);  check_bits("R4 -max", y, 64'hFFF8_0000_0000_0000);
        apply(64'h8000_0000_0000_0003, 1'b0, y, v);  check_bits("R4 -subnormal", y, 64'hFFF8_0000_0000_0000);
        apply(64'h7FF0_0000_0000_0001, 1'b0, y, v);  check_bits("R5 snan", y, 64'h7FF8_0000_0000_0001);
        apply(64'hFFF4_0000_0000_00AB, 1'b0, y, v);  check_bits("R5 -snan", y, 64'hFFFC_0000_0000_00AB);
        apply(64'hFFF8_0000_0000_1234, 1'b0, y, v);  check_bits("R5 qnan", y, 64'hFFF8_0000_0000_1234);
        apply(64'h7FFF_FFFF_FFFF_FFFF, 1'b1, y, v);  check_bits("R5 qnan all ones", y, 64'h7FFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_flush();
        logic [63:0] y;
        bit v;
        apply(64'h0000_0000_0000_0001, 1'b1, y, v);  check_bits("R6 +subnormal", y, 64'h7FF0_0000_0000_0000);
        apply(64'h800F_FFFF_FFFF_FFFF, 1'b1, y, v);  check_bits("R6 -subnormal", y, 64'hFFF0_0000_0000_0000);
        apply(64'h3FF0_0000_0000_0001, 1'b1, y, v);  check_close("R7 flush on normal", 64'h3FF0_0000_0000_0001, y);
        apply(64'h0010_0000_0000_0000, 1'b1, y, v);  check_close("R7 flush on min normal", 64'h0010_0000_0000_0000, y);
    endtask

    task automatic t_subnormal();
        logic [63:0] y;
        logic [63:0] x;
        bit v;
        for (int k = 0; k < 52; k += 3) begin
            x = {12'h000, (52'd1 << k) | 52'(k * 977)};
            apply(x, 1'b0, y, v);
            check_close("R7 subnormal", x, y);
        end
        apply(64'h000F_FFFF_FFFF_FFFF, 1'b0, y, v);  check_close("R7 max subnormal", 64'h000F_FFFF_FFFF_FFFF, y);
    endtask

    task automatic t_pow4();
        logic [63:0] y;
        bit v;
        for (int n = -511; n <= 511; n++) begin
            apply(mk(1'b0, 1023 - 2 * n, 52'h0), n[0], y, v);
            check_bits("R8 power of four", y, mk(1'b0, 1023 + n, 52'h0));
        end
        apply(64'h0000_0000_0000_0001, 1'b0, y, v);  check_bits("R8 2^-1074", y, mk(1'b0, 1023 + 537, 52'h0));
        apply(64'h0000_0000_0000_0004, 1'b0, y, v);  check_bits("R8 2^-1072", y, mk(1'b0, 1023 + 536, 52'h0));
        apply(64'h0004_0000_0000_0000, 1'b0, y, v);  check_bits("R8 2^-1024", y, mk(1'b0, 1023 + 512, 52'h0));
    endtask

    task automatic t_sweep();
        logic [63:0] y;
        logic [63:0] x;
        logic [51:0] f;
        bit v;
        for (int odd = 0; odd < 2; odd++) begin
            for (int t = 0; t < 64; t++) begin
                for (int j = 0; j < 3; j++) begin
                    f = (52'(t) << 46) | ((j == 0) ? 52'd1 : (j == 1) ? (52'd1 << 45) : ((52'd1 << 46) - 52'd1));
                    x = mk(1'b0, 1023 + odd, f);
                    apply(x, 1'b0, y, v);
                    check_close("R1 sweep", x, y);
                    x = mk(1'b0, 1 + ((t * 37 + j * 11) * 2 + odd) % 2046, f);
                    apply(x, 1'b0, y, v);
                    check_close("R1 exponent spread", x, y);
                end
            end
        end
        apply(64'h7FEF_FFFF_FFFF_FFFF, 1'b0, y, v);  check_close("R1 max normal", 64'h7FEF_FFFF_FFFF_FFFF, y);
    endtask

    task automatic t_stream();
        logic [63:0] vals [24];
        logic [63:0] x;
        for (int k = 0; k < 24; k++)
            vals[k] = mk(1'b0, 900 + 17 * k, 52'(64'(k) * 64'h0001_2345_6789_ABCD));
        for (int k = 0; k < 27; k++) begin
            @(negedge clk);
            total++;
            if (out_valid !== (k >= 3)) begin
                bad++;
                $display("FAIL R9: stream slot %0d out_valid got %b expected %b", k, out_valid, (k >= 3));
            end
            if (k >= 3) check_close("R9 stream order", vals[k-3], out_data);
            if (k < 24) begin
                in_valid  = 1'b1;
                in_data   = vals[k];
                flush_sub = 1'b0;
            end else begin
                in_valid = 1'b0;
            end
        end
        x = out_data;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R9: strobe after stream got %b expected 0 (last %h)", out_valid, x);
        end
    endtask

    task automatic t_midreset();
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = mk(1'b0, 1000 + k, 52'h0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            total++;
            if (out_valid !== 1'b0) begin
                bad++;
                $display("FAIL R10: in-flight result after reset, slot %0d got %b expected 0", k, out_valid);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_specials();
        t_flush();
        t_subnormal();
        t_pow4();
        t_sweep();
        t_stream();
        t_midreset();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, got no end expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule